// File: doc/BRIEF.md
# Trap Entry Sequencer

This block carries out the state changes a register-window processor makes when it takes a trap. The pipeline presents a one-cycle strobe with an 8-bit trap type, plus the current fetch address, the following fetch address, the window pointer, the supervisor bit, the enable-traps bit and the trap base register. One clock later the sequencer returns the whole post-trap state. That state holds the status bits, the rotated window pointer, the rebuilt trap base register and the redirected fetch pair. It also returns two register-file write requests that save the interrupted fetch pair into the new window.

Two situations change the normal path. A trap presented while traps are disabled does not enter. It either raises a one-cycle shutdown request, for trap type 0x80 when the shutdown option is enabled, or puts the block in a sticky error state that refuses every later trap until reset. A floating-point exception trap enters as if taken by the next instruction. When the deferred-exception queue is empty, the faulting address and its instruction word are first loaded into that queue.

External interrupt traps also send an acknowledge pulse that carries the trap type to the interrupt controller.

Top module: `trap_entry_seq`

## Requirements
- R1: On an accepted entry the enable-traps result is 0, the previous-supervisor result equals the incoming supervisor bit, and the supervisor result is 1.
- R2: The new window pointer is the incoming pointer minus one, wrapping from 0 to NWIN-1.
- R3: On entry, saveWe pulses. The save address for the fetch address is new window × 16 + 9, and the save address for the next fetch address is new window × 16 + 10.
- R4: The new trap base register keeps bits 31:12 of the incoming one, holds the trap type in bits 11:4 and has bits 3:0 at zero. The new fetch address equals it and the new next fetch address is that value plus 4.
- R5: All entry results, takeValid, ackValid and shutdownReq appear on the cycle after the strobe and last for one cycle.
- R6: A trap presented with enable-traps at 0, other than the shutdown case, sets errState. errState stays set until reset, and while it is set no strobe produces takeValid, a save or an acknowledge.
- R7: Trap type 0x80 with enable-traps at 0 and shutdownEn at 1 pulses shutdownReq. It sets no error and performs no entry.
- R8: For trap type 0x08 (floating-point exception), the saved fetch address is the incoming next fetch address and the saved next fetch address is that plus 4.
- R9: A type 0x08 entry with fqValid at 0 loads fqAddr with the incoming fetch address and fqInsn with faultInsn, and sets fqValid. With fqValid at 1 the queue is left unchanged.
- R10: An entry whose trap type has bits 7:4 equal to 1 (types 0x10 to 0x1F) pulses ackValid with ackType equal to the trap type. Other types give no acknowledge.
- R11: fqPop clears fqValid when no queue load happens in the same cycle.
- R12: After reset takeValid, saveWe, ackValid, shutdownReq, errState and fqValid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trapValid | input | 1 | One-cycle trap request strobe |
| trapType | input | 8 | Trap type |
| curPc | input | 32 | Current fetch address |
| curNpc | input | 32 | Next fetch address |
| curCwp | input | $clog2(NWIN) | Current window pointer |
| curEt | input | 1 | Enable-traps bit |
| curS | input | 1 | Supervisor bit |
| curTbr | input | 32 | Current trap base register |
| faultInsn | input | 32 | Instruction word at curPc |
| shutdownEn | input | 1 | Allows trap 0x80 with traps disabled to request shutdown |
| fqPop | input | 1 | Drains the deferred floating-point queue entry |
| takeValid | output | 1 | Entry results valid |
| newPc | output | 32 | Redirected fetch address |
| newNpc | output | 32 | Redirected next fetch address |
| newCwp | output | $clog2(NWIN) | New window pointer |
| newEt | output | 1 | New enable-traps bit |
| newS | output | 1 | New supervisor bit |
| newPs | output | 1 | New previous-supervisor bit |
| newTbr | output | 32 | New trap base register |
| saveWe | output | 1 | Write enable for both save ports |
| savePcAddr | output | $clog2(NWIN)+4 | Register address for saved fetch address |
| savePcData | output | 32 | Saved fetch address |
| saveNpcAddr | output | $clog2(NWIN)+4 | Register address for saved next fetch address |
| saveNpcData | output | 32 | Saved next fetch address |
| ackValid | output | 1 | Interrupt acknowledge pulse |
| ackType | output | 8 | Trap type being acknowledged |
| shutdownReq | output | 1 | Shutdown request pulse |
| errState | output | 1 | Sticky error state |
| fqValid | output | 1 | Deferred floating-point queue not empty |
| fqAddr | output | 32 | Queued faulting address |
| fqInsn | output | 32 | Queued instruction word |

## Verification
Every result is due exactly one clock after the strobe edge. Entry results, saves, the acknowledge, the shutdown request, errState and the queue fields are all written by registers loaded from that strobe. The bench raises the strobe just after a falling edge and drops it at the next falling edge. It then compares all outputs at that falling edge, which lies half a period after the capturing rising edge. Pulse outputs are checked again one cycle later to confirm they have returned to 0.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  typedef struct packed {
    logic take;      // perform a trap entry
    logic fpTrap;    // entry is a deferred floating-point exception
    logic fqLoad;    // load the empty floating-point queue
    logic extAck;    // acknowledge an external interrupt
    logic shutdown;  // request shutdown instead of entry
  } trapStrobe_t;
endpackage

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_seq_pkg::*;
#(
  parameter logic [7:0] FP_TT   = 8'h08,
  parameter logic [3:0] EXT_HI  = 4'h1,
  parameter logic [7:0] HALT_TT = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trapValid,
  input  logic [7:0]  trapType,
  input  logic        curEt,
  input  logic        shutdownEn,
  input  logic        fqValid,
  output trapStrobe_t str,
  output logic        errState
);
  logic accept;
  logic haltCase;
  logic goErr;

  assign accept   = trapValid && !errState;
  assign haltCase = (trapType == HALT_TT) && shutdownEn;
  assign goErr    = accept && !curEt && !haltCase;

  always_comb begin
    str.take     = accept && curEt;
    str.fpTrap   = accept && curEt && (trapType == FP_TT);
    str.fqLoad   = accept && curEt && (trapType == FP_TT) && !fqValid;
    str.extAck   = accept && curEt && (trapType[7:4] == EXT_HI);
    str.shutdown = accept && !curEt && haltCase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     errState <= 1'b0;
    else if (goErr) errState <= 1'b1;
  end

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errState |=> errState);

  // R6
  err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errState |-> !(str.take || str.shutdown));

  // R7
  halt_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (str.shutdown && !errState) |=> !errState);
endmodule

// File: rtl/trap_seq_dp.sv
module trap_seq_dp
  import trap_seq_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int RA = CW + 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  trapStrobe_t    str,
  input  logic [7:0]     trapType,
  input  logic [31:0]    curPc,
  input  logic [31:0]    curNpc,
  input  logic [CW-1:0]  curCwp,
  input  logic           curS,
  input  logic [31:0]    curTbr,
  input  logic [31:0]    faultInsn,
  input  logic           fqPop,
  output logic           takeValid,
  output logic [31:0]    newPc,
  output logic [31:0]    newNpc,
  output logic [CW-1:0]  newCwp,
  output logic           newEt,
  output logic           newS,
  output logic           newPs,
  output logic [31:0]    newTbr,
  output logic           saveWe,
  output logic [RA-1:0]  savePcAddr,
  output logic [31:0]    savePcData,
  output logic [RA-1:0]  saveNpcAddr,
  output logic [31:0]    saveNpcData,
  output logic           ackValid,
  output logic [7:0]     ackType,
  output logic           shutdownReq,
  output logic           fqValid,
  output logic [31:0]    fqAddr,
  output logic [31:0]    fqInsn
);
  localparam logic [CW-1:0] TOP_WIN = CW'(NWIN - 1);
  localparam logic [3:0]    PC_SLOT  = 4'd9;
  localparam logic [3:0]    NPC_SLOT = 4'd10;

  logic [CW-1:0] cwpNext;
  logic [31:0]   tbrNext;
  logic [31:0]   keepPc;
  logic [31:0]   keepNpc;

  assign cwpNext = (curCwp == '0) ? TOP_WIN : curCwp - 1'b1;
  assign tbrNext = {curTbr[31:12], trapType, 4'h0};
  assign keepPc  = str.fpTrap ? curNpc : curPc;
  assign keepNpc = str.fpTrap ? curNpc + 32'd4 : curNpc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      takeValid   <= 1'b0;
      saveWe      <= 1'b0;
      ackValid    <= 1'b0;
      shutdownReq <= 1'b0;
      newPc       <= '0;
      newNpc      <= '0;
      newCwp      <= '0;
      newEt       <= 1'b0;
      newS        <= 1'b0;
      newPs       <= 1'b0;
      newTbr      <= '0;
      savePcAddr  <= '0;
      saveNpcAddr <= '0;
      savePcData  <= '0;
      saveNpcData <= '0;
      ackType     <= '0;
    end else begin
      takeValid   <= str.take;
      saveWe      <= str.take;
      ackValid    <= str.extAck;
      shutdownReq <= str.shutdown;
      if (str.take) begin
        newTbr      <= tbrNext;
        newPc       <= tbrNext;
        newNpc      <= tbrNext + 32'd4;
        newCwp      <= cwpNext;
        newEt       <= 1'b0;
        newS        <= 1'b1;
        newPs       <= curS;
        savePcAddr  <= {cwpNext, PC_SLOT};
        saveNpcAddr <= {cwpNext, NPC_SLOT};
        savePcData  <= keepPc;
        saveNpcData <= keepNpc;
        ackType     <= trapType;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fqValid <= 1'b0;
      fqAddr  <= '0;
      fqInsn  <= '0;
    end else if (str.fqLoad) begin
      fqValid <= 1'b1;
      fqAddr  <= curPc;
      fqInsn  <= faultInsn;
    end else if (fqPop) begin
      fqValid <= 1'b0;
    end
  end

  // R2
  cwp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.take |=> newCwp == (($past(curCwp) == '0) ? TOP_WIN : $past(curCwp) - 1'b1));

  // R4
  npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    takeValid |-> (newNpc == newPc + 32'd4) && (newPc[3:0] == 4'h0));

  // R3
  save_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    saveWe |-> (saveNpcAddr == savePcAddr + 1'b1) && (savePcAddr[RA-1:4] == newCwp));

  // R9
  fq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.fqLoad |=> fqValid && (fqAddr == $past(curPc)));

  // R10
  ack_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |-> takeValid && (ackType[7:4] == 4'h1));
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int RA = CW + 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trapValid,
  input  logic [7:0]     trapType,
  input  logic [31:0]    curPc,
  input  logic [31:0]    curNpc,
  input  logic [CW-1:0]  curCwp,
  input  logic           curEt,
  input  logic           curS,
  input  logic [31:0]    curTbr,
  input  logic [31:0]    faultInsn,
  input  logic           shutdownEn,
  input  logic           fqPop,
  output logic           takeValid,
  output logic [31:0]    newPc,
  output logic [31:0]    newNpc,
  output logic [CW-1:0]  newCwp,
  output logic           newEt,
  output logic           newS,
  output logic           newPs,
  output logic [31:0]    newTbr,
  output logic           saveWe,
  output logic [RA-1:0]  savePcAddr,
  output logic [31:0]    savePcData,
  output logic [RA-1:0]  saveNpcAddr,
  output logic [31:0]    saveNpcData,
  output logic           ackValid,
  output logic [7:0]     ackType,
  output logic           shutdownReq,
  output logic           errState,
  output logic           fqValid,
  output logic [31:0]    fqAddr,
  output logic [31:0]    fqInsn
);
  trapStrobe_t str;

  trap_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trapValid  (trapValid),
    .trapType   (trapType),
    .curEt      (curEt),
    .shutdownEn (shutdownEn),
    .fqValid    (fqValid),
    .str        (str),
    .errState   (errState)
  );

  trap_seq_dp #(.NWIN(NWIN)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .str         (str),
    .trapType    (trapType),
    .curPc       (curPc),
    .curNpc      (curNpc),
    .curCwp      (curCwp),
    .curS        (curS),
    .curTbr      (curTbr),
    .faultInsn   (faultInsn),
    .fqPop       (fqPop),
    .takeValid   (takeValid),
    .newPc       (newPc),
    .newNpc      (newNpc),
    .newCwp      (newCwp),
    .newEt       (newEt),
    .newS        (newS),
    .newPs       (newPs),
    .newTbr      (newTbr),
    .saveWe      (saveWe),
    .savePcAddr  (savePcAddr),
    .savePcData  (savePcData),
    .saveNpcAddr (saveNpcAddr),
    .saveNpcData (saveNpcData),
    .ackValid    (ackValid),
    .ackType     (ackType),
    .shutdownReq (shutdownReq),
    .fqValid     (fqValid),
    .fqAddr      (fqAddr),
    .fqInsn      (fqInsn)
  );

  // R5
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trapValid && curEt && !errState) |=> takeValid);

  // R1
  status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trapValid && curEt && !errState) |=> (!newEt && newS && (newPs == $past(curS))));
endmodule

// File: tb/sim_trap_entry_seq.sv
module sim_trap_entry_seq;
  localparam int NWIN = 8;
  localparam int CW = 3;
  localparam int RA = CW + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trapValid = 1'b0;
  logic [7:0] trapType = '0;
  logic [31:0] curPc = '0, curNpc = '0, curTbr = '0, faultInsn = '0;
  logic [CW-1:0] curCwp = '0;
  logic curEt = 1'b1, curS = 1'b0, shutdownEn = 1'b0, fqPop = 1'b0;

  logic takeValid, newEt, newS, newPs, saveWe, ackValid, shutdownReq, errState, fqValid;
  logic [31:0] newPc, newNpc, newTbr, savePcData, saveNpcData, fqAddr, fqInsn;
  logic [CW-1:0] newCwp;
  logic [RA-1:0] savePcAddr, saveNpcAddr;
  logic [7:0] ackType;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  trap_entry_seq #(.NWIN(NWIN)) u0 (
    .clk(clk), .rst_n(rst_n), .trapValid(trapValid), .trapType(trapType),
    .curPc(curPc), .curNpc(curNpc), .curCwp(curCwp), .curEt(curEt), .curS(curS),
    .curTbr(curTbr), .faultInsn(faultInsn), .shutdownEn(shutdownEn), .fqPop(fqPop),
    .takeValid(takeValid), .newPc(newPc), .newNpc(newNpc), .newCwp(newCwp),
    .newEt(newEt), .newS(newS), .newPs(newPs), .newTbr(newTbr), .saveWe(saveWe),
    .savePcAddr(savePcAddr), .savePcData(savePcData), .saveNpcAddr(saveNpcAddr),
    .saveNpcData(saveNpcData), .ackValid(ackValid), .ackType(ackType),
    .shutdownReq(shutdownReq), .errState(errState), .fqValid(fqValid),
    .fqAddr(fqAddr), .fqInsn(fqInsn)
  );

  typedef struct packed {
    logic [7:0]  tt;
    logic [31:0] pc;
    logic [31:0] npc;
    logic [2:0]  cwp;
    logic        s;
    logic [31:0] tbr;
    logic [31:0] insn;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h05, 32'h0000_1000, 32'h0000_1004, 3'd3, 1'b0, 32'hABCD_E123, 32'h1111_1111},
    '{8'h1A, 32'h0000_4440, 32'h0000_4444, 3'd0, 1'b1, 32'h1234_5FFF, 32'h2222_2222},
    '{8'h08, 32'h0000_2000, 32'h0000_2008, 3'd5, 1'b0, 32'h8000_0000, 32'h81A0_0020},
    '{8'h08, 32'h0000_3000, 32'h0000_3004, 3'd1, 1'b1, 32'h8000_0000, 32'h3333_3333},
    '{8'hFF, 32'hFFFF_FFF8, 32'hFFFF_FFFC, 3'd7, 1'b1, 32'hFFFF_F000, 32'h4444_4444},
    '{8'h80, 32'h0000_5000, 32'h0000_5004, 3'd2, 1'b0, 32'h0000_0ABC, 32'h5555_5555}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic fire(input logic [7:0] tt, input logic [31:0] pc, input logic [31:0] npc,
                      input logic [2:0] cwp, input logic s, input logic [31:0] tbr,
                      input logic [31:0] insn, input logic et);
    trapType = tt; curPc = pc; curNpc = npc; curCwp = cwp; curS = s;
    curTbr = tbr; faultInsn = insn; curEt = et; trapValid = 1'b1;
    @(negedge clk);
    trapValid = 1'b0;
  endtask

  logic expFqValid = 1'b0;
  logic [31:0] expFqAddr = '0;
  logic [31:0] expFqInsn = '0;

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: got hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset values
    chk("R12 takeValid", takeValid, 0);
    chk("R12 saveWe", saveWe, 0);
    chk("R12 ackValid", ackValid, 0);
    chk("R12 shutdownReq", shutdownReq, 0);
    chk("R12 errState", errState, 0);
    chk("R12 fqValid", fqValid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      vec_t v;
      logic [2:0] eCwp;
      logic [31:0] eTbr, ePc, eNpc;
      logic fp;
      v = VECS[i];
      fp = (v.tt == 8'h08);
      eCwp = (v.cwp == 3'd0) ? 3'd7 : v.cwp - 3'd1;
      eTbr = {v.tbr[31:12], v.tt, 4'h0};
      ePc  = fp ? v.npc : v.pc;
      eNpc = fp ? v.npc + 32'd4 : v.npc;
      if (fp && !expFqValid) begin
        expFqValid = 1'b1; expFqAddr = v.pc; expFqInsn = v.insn;
      end
      fire(v.tt, v.pc, v.npc, v.cwp, v.s, v.tbr, v.insn, 1'b1);
      chk("R5 takeValid", takeValid, 1);
      chk("R1 newEt", newEt, 0);
      chk("R1 newS", newS, 1);
      chk("R1 newPs", newPs, v.s);
      chk("R2 newCwp", newCwp, eCwp);
      chk("R4 newTbr", newTbr, eTbr);
      chk("R4 newPc", newPc, eTbr);
      chk("R4 newNpc", newNpc, eTbr + 32'd4);
      chk("R3 saveWe", saveWe, 1);
      chk("R3 savePcAddr", savePcAddr, {eCwp, 4'd9});
      chk("R3 saveNpcAddr", saveNpcAddr, {eCwp, 4'd10});
      chk("R8 savePcData", savePcData, ePc);
      chk("R8 saveNpcData", saveNpcData, eNpc);
      chk("R10 ackValid", ackValid, v.tt[7:4] == 4'h1);
      if (v.tt[7:4] == 4'h1) chk("R10 ackType", ackType, v.tt);
      chk("R7 shutdownReq with traps enabled", shutdownReq, 0);
      chk("R9 fqValid", fqValid, expFqValid);
      chk("R9 fqAddr", fqAddr, expFqAddr);
      chk("R9 fqInsn", fqInsn, expFqInsn);
      @(negedge clk);
      chk("R5 takeValid drop", takeValid, 0);
      chk("R5 saveWe drop", saveWe, 0);
      chk("R5 ackValid drop", ackValid, 0);
    end

    // R11 pop clears queue
    fqPop = 1'b1;
    @(negedge clk);
    fqPop = 1'b0;
    chk("R11 fqValid cleared", fqValid, 0);

    // R7 shutdown with traps disabled
    shutdownEn = 1'b1;
    fire(8'h80, 32'h6000, 32'h6004, 3'd4, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R7 shutdownReq", shutdownReq, 1);
    chk("R7 no entry", takeValid, 0);
    chk("R7 no error", errState, 0);
    @(negedge clk);
    chk("R7 shutdownReq drop", shutdownReq, 0);

    // R6 trap with traps disabled -> error
    fire(8'h05, 32'h7000, 32'h7004, 3'd4, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R6 errState set", errState, 1);
    chk("R6 no entry", takeValid, 0);
    // R6 later trap refused
    fire(8'h12, 32'h7100, 32'h7104, 3'd4, 1'b1, 32'h0, 32'h0, 1'b1);
    chk("R6 refused take", takeValid, 0);
    chk("R6 refused save", saveWe, 0);
    chk("R6 refused ack", ackValid, 0);
    chk("R6 errState sticky", errState, 1);
    // R6 refused shutdown as well
    fire(8'h80, 32'h7200, 32'h7204, 3'd4, 1'b1, 32'h0, 32'h0, 1'b0);
    chk("R6 refused shutdown", shutdownReq, 0);
    // R6 refused FP trap leaves queue empty
    fire(8'h08, 32'h7300, 32'h7304, 3'd4, 1'b1, 32'h0, 32'h9, 1'b1);
    chk("R6 queue untouched", fqValid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule